// File: doc/BRIEF.md
# Serial Port Bit Clock and Frame Sync Generator

This block sits beside the data shifters of a serial port and supplies their timing. It takes either the system clock or an external clock input as its source and divides it by a programmable factor. The result is a one-cycle bit strobe in the system clock domain, together with a square-ish bit clock level for the clock pins.

The same strobe advances a frame position counter. From that position the block derives a periodic frame sync with a programmable period and pulse width. The transmit sync can come from this periodic generator. It can instead follow the transmitter: one sync bit period after each word load.

Four direction bits decide, for each of the receive clock, transmit clock, receive sync and transmit sync pins, whether the block drives the pin or takes the signal from outside. The effective signal is presented to the shifters either way.

While the run input is low, every counter and every generated output is held at zero. Raising run starts a fresh frame.

Top module: `sclk_fsync_gen`

## Requirements
- R1: With `src_ext` = 0 the source ticks every system cycle. `bit_stb` pulses once every `clk_div` + 1 cycles. The first pulse comes `clk_div` + 1 cycles after the first clock edge that samples `gen_run` high. Two strobes are never adjacent unless `clk_div` = 0.
- R2: With `src_ext` = 1 the source ticks once for each rising edge of `ext_clk`. The edge is taken through a two-stage synchronizer and an edge detector, and `bit_stb` pulses once every `clk_div` + 1 ticks.
- R3: The generated bit clock level is high while the divider count is below floor((`clk_div` + 1) / 2). Within each bit period of `clk_div` + 1 system cycles, that gives exactly that many high cycles.
- R4: Bit periods are numbered from 0 after run rises, and a frame spans `fs_period` + 1 bit periods. The periodic sync is high in the bit periods at frame positions 0 through `fs_width`. It changes only together with a bit strobe or when run drops.
- R5: If `fs_width` >= `fs_period`, the periodic sync is clipped so that it is high at positions 0 through `fs_period` − 1 only. With `fs_period` = 0 it stays low.
- R6: With `fs_periodic` = 0, the transmit sync is high for exactly the one bit period that starts at the first strobe after a `tx_word_load` pulse. At all other times it is low.
- R7: The receive sync is always the periodic sync. The transmit sync equals it when `fs_periodic` = 1.
- R8: While `gen_run` is low, `bit_stb`, the bit clock level and both syncs are 0 from the next edge on. A new run restarts the divider and the frame at position 0, whatever position the previous run stopped at.
- R9: For each pin, the output enable equals its direction bit. The pin output carries the generated signal. The effective signal equals the generated signal when the bit is 1 and the pin input when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_run | input | 1 | Generator enable; low holds and restarts all counters |
| ext_clk | input | 1 | External source clock, asynchronous |
| src_ext | input | 1 | Source select: 0 system clock, 1 external clock |
| clk_div | input | DIV_W | Divider value; bit period is clk_div + 1 source ticks |
| fs_period | input | PER_W | Frame length minus one, in bit periods |
| fs_width | input | WID_W | Sync pulse length minus one, in bit periods |
| fs_periodic | input | 1 | Transmit sync source: 0 word loads, 1 periodic |
| tx_word_load | input | 1 | One-cycle pulse when a transmit word enters the shifter |
| dir_rclk | input | 1 | Receive clock pin direction (1 drive) |
| dir_xclk | input | 1 | Transmit clock pin direction (1 drive) |
| dir_rfs | input | 1 | Receive sync pin direction (1 drive) |
| dir_xfs | input | 1 | Transmit sync pin direction (1 drive) |
| rclk_pin_i | input | 1 | Receive clock pin input |
| xclk_pin_i | input | 1 | Transmit clock pin input |
| rfs_pin_i | input | 1 | Receive sync pin input |
| xfs_pin_i | input | 1 | Transmit sync pin input |
| rclk_pin_o | output | 1 | Receive clock pin output value |
| xclk_pin_o | output | 1 | Transmit clock pin output value |
| rfs_pin_o | output | 1 | Receive sync pin output value |
| xfs_pin_o | output | 1 | Transmit sync pin output value |
| rclk_pin_oe | output | 1 | Receive clock pin output enable |
| xclk_pin_oe | output | 1 | Transmit clock pin output enable |
| rfs_pin_oe | output | 1 | Receive sync pin output enable |
| xfs_pin_oe | output | 1 | Transmit sync pin output enable |
| bit_stb | output | 1 | One-cycle strobe at the start of each bit period |
| rx_clk | output | 1 | Effective receive clock for the shifter |
| tx_clk | output | 1 | Effective transmit clock for the shifter |
| rx_fs | output | 1 | Effective receive sync for the shifter |
| tx_fs | output | 1 | Effective transmit sync for the shifter |

## Verification
A divider count that goes wrong shows up at the very next strobe as a wrong gap between `bit_stb` pulses. It also shows as a wrong number of high cycles on the clock pins within that bit period. A frame position error appears as a sync pattern shifted or stretched within at most one frame. A stale load flag appears as a transmit sync in the wrong bit period, one strobe after the load. Every strobe is therefore compared with its predicted gap, level count and both sync values. Each run restart is checked so that no state carries over between runs.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    localparam int DEF_DIV_W   = 8;
    localparam int DEF_PER_W   = 12;
    localparam int DEF_WID_W   = 8;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_PINS    = 4;

    // Pin slots in the direction / generated / effective vectors
    localparam int PIN_RCLK = 0;
    localparam int PIN_XCLK = 1;
    localparam int PIN_RFS  = 2;
    localparam int PIN_XFS  = 3;

    typedef enum logic {
        SRC_SYS = 1'b0,
        SRC_EXT = 1'b1
    } src_sel_e;

    typedef enum logic {
        FS_ON_LOAD  = 1'b0,
        FS_PERIODIC = 1'b1
    } fs_mode_e;

endpackage

// File: rtl/sfg_src_tick.sv
module sfg_src_tick #(
    parameter int STAGES = sfg_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_ext_i,
    input  logic ext_clk_i,
    output logic tick_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t s_d, s_q;
    sfg_pkg::src_sel_e sel;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], ext_clk_i};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        sel = sfg_pkg::src_sel_e'(src_ext_i);
        if (sel == sfg_pkg::SRC_EXT) tick_o = s_q.sync[STAGES-1] & ~s_q.prev;
        else                         tick_o = 1'b1;
    end

    AST_EXT_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i && tick_o) |=> !(src_ext_i && tick_o)); // R2

endmodule

// File: rtl/sfg_clkdiv.sv
module sfg_clkdiv #(
    parameter int DIV_W = sfg_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             stb_o,
    output logic             bit_stb_o,
    output logic             bclk_o
);

    localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);
    localparam logic [DIV_W:0]   WIDE_ONE = (DIV_W+1)'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             stb;
        logic             lvl;
    } st_t;

    st_t            s_d, s_q;
    logic [DIV_W:0] half;
    logic           hit;

    always_comb begin
        half = ({1'b0, div_i} + WIDE_ONE) >> 1;
        hit  = run_i && tick_i && (s_q.cnt >= div_i);
        s_d  = s_q;
        if (!run_i) begin
            s_d = '0;
        end else begin
            if (hit)         s_d.cnt = '0;
            else if (tick_i) s_d.cnt = s_q.cnt + CNT_ONE;
            s_d.stb = hit;
            s_d.lvl = ({1'b0, s_d.cnt} < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stb_o     = hit;
    assign bit_stb_o = s_q.stb;
    assign bclk_o    = s_q.lvl;

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> (!bit_stb_o || div_i == '0)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!bit_stb_o && !bclk_o)); // R8

endmodule

// File: rtl/sfg_fsync.sv
module sfg_fsync #(
    parameter int PER_W = sfg_pkg::DEF_PER_W,
    parameter int WID_W = sfg_pkg::DEF_WID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             stb_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [WID_W-1:0] wid_i,
    input  logic             load_i,
    output logic             fs_per_o,
    output logic             fs_ld_o
);

    localparam logic [PER_W-1:0] POS_ONE = PER_W'(1);

    typedef struct packed {
        logic [PER_W-1:0] pos;
        logic             fs_per;
        logic             fs_ld;
        logic             pend;
    } st_t;

    st_t              s_d, s_q;
    logic [PER_W-1:0] wid_ext;
    logic             active;

    always_comb begin
        wid_ext = PER_W'(wid_i);
        // high for positions 0..width, never in the last position of a frame
        active  = (s_q.pos <= wid_ext) && (s_q.pos < per_i);
        s_d     = s_q;
        if (!run_i) begin
            s_d = '0;
        end else begin
            s_d.pend = s_q.pend | load_i;
            if (stb_i) begin
                s_d.fs_per = active;
                s_d.fs_ld  = s_q.pend | load_i;
                s_d.pend   = 1'b0;
                s_d.pos    = (s_q.pos >= per_i) ? '0 : s_q.pos + POS_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fs_per_o = s_q.fs_per;
    assign fs_ld_o  = s_q.fs_ld;

    AST_FRAME_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pos == '0) |-> !s_q.fs_per); // R5

endmodule

// File: rtl/sfg_pinmux.sv
module sfg_pinmux #(
    parameter int N = sfg_pkg::NUM_PINS
) (
    input  logic [N-1:0] dir_i,
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] pin_o,
    output logic [N-1:0] pin_oe_o,
    output logic [N-1:0] eff_o
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pin_o[i]    = gen_i[i];
        assign pin_oe_o[i] = dir_i[i];
        assign eff_o[i]    = dir_i[i] ? gen_i[i] : pin_i[i];
    end

endmodule

// File: rtl/sclk_fsync_gen.sv
module sclk_fsync_gen #(
    parameter int DIV_W = sfg_pkg::DEF_DIV_W,
    parameter int PER_W = sfg_pkg::DEF_PER_W,
    parameter int WID_W = sfg_pkg::DEF_WID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_run,
    input  logic             ext_clk,
    input  logic             src_ext,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [PER_W-1:0] fs_period,
    input  logic [WID_W-1:0] fs_width,
    input  logic             fs_periodic,
    input  logic             tx_word_load,
    input  logic             dir_rclk,
    input  logic             dir_xclk,
    input  logic             dir_rfs,
    input  logic             dir_xfs,
    input  logic             rclk_pin_i,
    input  logic             xclk_pin_i,
    input  logic             rfs_pin_i,
    input  logic             xfs_pin_i,
    output logic             rclk_pin_o,
    output logic             xclk_pin_o,
    output logic             rfs_pin_o,
    output logic             xfs_pin_o,
    output logic             rclk_pin_oe,
    output logic             xclk_pin_oe,
    output logic             rfs_pin_oe,
    output logic             xfs_pin_oe,
    output logic             bit_stb,
    output logic             rx_clk,
    output logic             tx_clk,
    output logic             rx_fs,
    output logic             tx_fs
);

    import sfg_pkg::*;

    logic                tick, stb_now, bclk_lvl, fs_per, fs_ld, tx_fs_gen;
    logic [NUM_PINS-1:0] dir_v, gen_v, pin_in_v, pin_out_v, pin_oe_v, eff_v;
    fs_mode_e            mode;

    sfg_src_tick #(.STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_ext_i (src_ext),
        .ext_clk_i (ext_clk),
        .tick_o    (tick)
    );

    sfg_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (gen_run),
        .tick_i    (tick),
        .div_i     (clk_div),
        .stb_o     (stb_now),
        .bit_stb_o (bit_stb),
        .bclk_o    (bclk_lvl)
    );

    sfg_fsync #(.PER_W(PER_W), .WID_W(WID_W)) u_fs (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (gen_run),
        .stb_i    (stb_now),
        .per_i    (fs_period),
        .wid_i    (fs_width),
        .load_i   (tx_word_load),
        .fs_per_o (fs_per),
        .fs_ld_o  (fs_ld)
    );

    always_comb begin
        mode      = fs_mode_e'(fs_periodic);
        tx_fs_gen = (mode == FS_PERIODIC) ? fs_per : fs_ld;

        dir_v[PIN_RCLK] = dir_rclk;
        dir_v[PIN_XCLK] = dir_xclk;
        dir_v[PIN_RFS]  = dir_rfs;
        dir_v[PIN_XFS]  = dir_xfs;

        gen_v[PIN_RCLK] = bclk_lvl;
        gen_v[PIN_XCLK] = bclk_lvl;
        gen_v[PIN_RFS]  = fs_per;
        gen_v[PIN_XFS]  = tx_fs_gen;

        pin_in_v[PIN_RCLK] = rclk_pin_i;
        pin_in_v[PIN_XCLK] = xclk_pin_i;
        pin_in_v[PIN_RFS]  = rfs_pin_i;
        pin_in_v[PIN_XFS]  = xfs_pin_i;
    end

    sfg_pinmux #(.N(NUM_PINS)) u_pin (
        .dir_i    (dir_v),
        .gen_i    (gen_v),
        .pin_i    (pin_in_v),
        .pin_o    (pin_out_v),
        .pin_oe_o (pin_oe_v),
        .eff_o    (eff_v)
    );

    assign rclk_pin_o  = pin_out_v[PIN_RCLK];
    assign xclk_pin_o  = pin_out_v[PIN_XCLK];
    assign rfs_pin_o   = pin_out_v[PIN_RFS];
    assign xfs_pin_o   = pin_out_v[PIN_XFS];
    assign rclk_pin_oe = pin_oe_v[PIN_RCLK];
    assign xclk_pin_oe = pin_oe_v[PIN_XCLK];
    assign rfs_pin_oe  = pin_oe_v[PIN_RFS];
    assign xfs_pin_oe  = pin_oe_v[PIN_XFS];
    assign rx_clk      = eff_v[PIN_RCLK];
    assign tx_clk      = eff_v[PIN_XCLK];
    assign rx_fs       = eff_v[PIN_RFS];
    assign tx_fs       = eff_v[PIN_XFS];

    AST_SYNC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fs_per) |-> (bit_stb || !$past(gen_run))); // R4

endmodule

// File: tb/sclk_fsync_gen_test.sv
module sclk_fsync_gen_test;

    localparam int DIV_W = 8;
    localparam int PER_W = 12;
    localparam int WID_W = 8;
    localparam int EXT_RATIO = 6;

    logic clk = 1'b0, rst_n = 1'b0, gen_run = 1'b0, ext_clk = 1'b0, src_ext = 1'b0;
    logic [DIV_W-1:0] clk_div = '0;
    logic [PER_W-1:0] fs_period = '0;
    logic [WID_W-1:0] fs_width = '0;
    logic fs_periodic = 1'b1, tx_word_load = 1'b0;
    logic dir_rclk = 1'b0, dir_xclk = 1'b0, dir_rfs = 1'b0, dir_xfs = 1'b0;
    logic rclk_pin_i = 1'b0, xclk_pin_i = 1'b0, rfs_pin_i = 1'b0, xfs_pin_i = 1'b0;
    logic rclk_pin_o, xclk_pin_o, rfs_pin_o, xfs_pin_o;
    logic rclk_pin_oe, xclk_pin_oe, rfs_pin_oe, xfs_pin_oe;
    logic bit_stb, rx_clk, tx_clk, rx_fs, tx_fs;

    typedef struct {
        int    gap;
        string gap_req;
        int    hi;
        bit    rfs;
        bit    xfs;
        string x_req;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0, errors = 0;
    bit          mon_on = 1'b0;
    int          mon_gap = 0, mon_hi = 0, mon_k = 0;
    logic [31:0] ld_pat = '0;

    always #2 clk = ~clk;
    always #12 ext_clk = ~ext_clk;   // one rising edge every 6 system cycles

    sclk_fsync_gen #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) uut (
        .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .ext_clk(ext_clk), .src_ext(src_ext),
        .clk_div(clk_div), .fs_period(fs_period), .fs_width(fs_width),
        .fs_periodic(fs_periodic), .tx_word_load(tx_word_load),
        .dir_rclk(dir_rclk), .dir_xclk(dir_xclk), .dir_rfs(dir_rfs), .dir_xfs(dir_xfs),
        .rclk_pin_i(rclk_pin_i), .xclk_pin_i(xclk_pin_i), .rfs_pin_i(rfs_pin_i), .xfs_pin_i(xfs_pin_i),
        .rclk_pin_o(rclk_pin_o), .xclk_pin_o(xclk_pin_o), .rfs_pin_o(rfs_pin_o), .xfs_pin_o(xfs_pin_o),
        .rclk_pin_oe(rclk_pin_oe), .xclk_pin_oe(xclk_pin_oe), .rfs_pin_oe(rfs_pin_oe), .xfs_pin_oe(xfs_pin_oe),
        .bit_stb(bit_stb), .rx_clk(rx_clk), .tx_clk(tx_clk), .rx_fs(rx_fs), .tx_fs(tx_fs)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: samples 1 time unit after each rising edge, pops one item per strobe
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tx_word_load = 1'b0;
            if (mon_on) begin
                mon_gap++;
                if (bit_stb) begin
                    if (sb_q.size() == 0) begin
                        check("R1", "strobe with empty scoreboard", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        if (e.gap >= 0) check(e.gap_req, "strobe gap", mon_gap, e.gap);
                        if (e.hi >= 0)  check("R3", "clock high cycles", mon_hi, e.hi);
                        check("R4", "receive sync", int'(rx_fs), int'(e.rfs));
                        check(e.x_req, "transmit sync", int'(tx_fs), int'(e.xfs));
                        if (ld_pat[mon_k]) tx_word_load = 1'b1;
                        mon_k++;
                    end
                    mon_gap = 0;
                    mon_hi  = 0;
                end
                mon_hi += int'(tx_clk);
            end
        end
    end

    // Driver: configures a run, pushes the predicted per-strobe items, waits for drain
    task automatic run_scn(input bit ext, input int div, input int per, input int wid,
                           input bit periodic, input int n, input logic [31:0] pat);
        @(negedge clk);
        src_ext     = ext;
        clk_div     = div[DIV_W-1:0];
        fs_period   = per[PER_W-1:0];
        fs_width    = wid[WID_W-1:0];
        fs_periodic = periodic;
        ld_pat      = pat;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            int   pos;
            pos     = k % (per + 1);
            e.rfs   = (pos <= wid) && (pos < per);   // R4 window, R5 clipping
            e.xfs   = periodic ? e.rfs : (k > 0 && pat[k-1]);
            e.x_req = periodic ? "R7" : "R6";
            e.gap_req = ext ? "R2" : "R1";
            if (k == 0) e.gap = ext ? -1 : div + 1;
            else        e.gap = ext ? (div + 1) * EXT_RATIO : div + 1;
            e.hi    = (ext || k == 0) ? -1 : (div + 1) / 2;
            sb_q.push_back(e);
        end
        mon_gap = 0;
        mon_hi  = 0;
        mon_k   = 0;
        mon_on  = 1'b1;
        gen_run = 1'b1;
        wait (sb_q.size() == 0);
        @(negedge clk);
        gen_run = 1'b0;
        mon_on  = 1'b0;
        @(posedge clk);
        #1;
        // R8: everything quiet one edge after run drops
        check("R8", "idle strobe", int'(bit_stb), 0);
        check("R8", "idle clock", int'(tx_clk), 0);
        check("R8", "idle rx sync", int'(rx_fs), 0);
        check("R8", "idle tx sync", int'(tx_fs), 0);
    endtask

    task automatic print_summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual 0 expected 1");
        print_summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8", "reset strobe", int'(bit_stb), 0);
        check("R8", "reset pin clock", int'(rclk_pin_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: all pins as inputs, effective signals follow the pin inputs
        rclk_pin_i = 1'b1; xclk_pin_i = 1'b1; rfs_pin_i = 1'b0; xfs_pin_i = 1'b1;
        @(posedge clk); #1;
        check("R9", "rx_clk from pin", int'(rx_clk), 1);
        check("R9", "tx_clk from pin", int'(tx_clk), 1);
        check("R9", "rx_fs from pin", int'(rx_fs), 0);
        check("R9", "tx_fs from pin", int'(tx_fs), 1);
        check("R9", "oe all off", int'({rclk_pin_oe, xclk_pin_oe, rfs_pin_oe, xfs_pin_oe}), 0);
        @(negedge clk);
        dir_rclk = 1'b1; dir_xfs = 1'b1;
        @(posedge clk); #1;
        check("R9", "rx_clk driven by generator", int'(rx_clk), 0);
        check("R9", "tx_clk still from pin", int'(tx_clk), 1);
        check("R9", "tx_fs driven by generator", int'(tx_fs), 0);
        check("R9", "oe mixed", int'({rclk_pin_oe, xclk_pin_oe, rfs_pin_oe, xfs_pin_oe}), 9);
        @(negedge clk);
        dir_xclk = 1'b1; dir_rfs = 1'b1;

        run_scn(1'b0, 3, 4, 1, 1'b1, 13, 32'h0);   // R1 R3 R4 R7, ends mid-frame
        run_scn(1'b0, 0, 3, 7, 1'b1, 10, 32'h0);   // R5 clip, R8 restart at position 0
        run_scn(1'b0, 2, 0, 0, 1'b1, 5, 32'h0);    // R5 zero period keeps sync low
        run_scn(1'b1, 1, 2, 0, 1'b1, 7, 32'h0);    // R2 external source
        run_scn(1'b0, 3, 7, 2, 1'b0, 10, 32'h32);  // R6 load-driven transmit sync

        print_summary();
        $finish;
    end

endmodule